// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block translates 32-bit effective addresses into physical addresses using a small set of software-loaded translation entries. All entries are searched at once. Each entry describes one page whose size is chosen per entry from five options, from 4 KB up to 8 MB. Each entry is tagged with a 4-bit address-space identifier, or is marked shared so that it matches in every address space. On a hit the block returns the physical address, the entry's 3-bit protection group, and a flag that is raised when more than one entry matched.

Software fills the buffer through a write port. Each write names a slot index and supplies the whole entry. A single-cycle invalidate-all command empties the buffer. The lookup is purely combinational, from the request inputs to the result outputs. The request is qualified by `lk_valid`. No ready signal exists on either port, because the block accepts a lookup and a write in every cycle and never applies back-pressure. Page-table walking, rights checking and caching belong to the surrounding logic.

Top module: `tlb_multisize`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until an entry has been written.
- R2: The 3-bit size code of an entry selects how many low effective-address bits are left out of the tag compare: code 0 leaves out 12 bits (4 KB), code 1 leaves out 14 (16 KB), code 2 leaves out 18 (256 KB), code 3 leaves out 19 (512 KB) and code 4 leaves out 23 (8 MB).
- R3: An entry matches only when its 4-bit space identifier equals `lk_asid`, unless its shared flag is set, in which case the identifier is ignored.
- R4: On a hit, `lk_pa` takes the entry's physical page bits above the page-size boundary and the effective-address bits below it. The low 12 bits therefore always equal `lk_ea[11:0]`.
- R5: On a hit, `lk_group` carries the 3-bit protection group of the winning entry.
- R6: When several valid entries match, the entry with the lowest index supplies the result and `lk_multi` is 1. With one match, `lk_multi` is 0.
- R7: A cycle with `inv_all` high clears every valid bit, so no lookup in the next cycle hits. If `wr_en` is also high in that cycle, the written slot ends up valid.
- R8: A write loads all fields of slot `wr_index` and marks it valid. The new contents become visible to lookups from the cycle after the write edge, and until then lookups see the old contents.
- R9: While `lk_valid` is 0, or on a miss, `lk_hit` and `lk_multi` are 0, and `lk_pa` and `lk_group` are all zeros.
- R10: Size codes 5, 6 and 7 behave exactly like code 0, a 4 KB page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_ea | input | 32 | Effective address to translate |
| lk_asid | input | 4 | Current address-space identifier |
| lk_hit | output | 1 | Translation found |
| lk_multi | output | 1 | More than one entry matched |
| lk_pa | output | 32 | Translated physical address |
| lk_group | output | 3 | Protection group of the winning entry |
| wr_en | input | 1 | Load an entry this cycle |
| wr_index | input | 5 | Slot to load |
| wr_epn | input | 20 | Effective page number (address bits 31:12) |
| wr_ppn | input | 20 | Physical page number (address bits 31:12) |
| wr_size | input | 3 | Page size code |
| wr_asid | input | 4 | Address-space identifier of the entry |
| wr_shared | input | 1 | Entry matches in every address space |
| wr_group | input | 3 | Protection group of the entry |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench probes each page size at the last byte inside the page and at the first byte past it. A design with a mask off by one bit would hit past the page, or miss inside it, and would merge the wrong address bits into the physical address. Two overlapping entries with different groups expose a priority encoder that favours the highest index or drops the multi-hit flag. The bench also covers reserved size codes, a shared entry used under a foreign identifier, a write observed before and after its edge, and an invalidate combined with a write in the same cycle. Each of these catches a design that masks wrongly, ignores the shared flag, shows a write too early, or lets the invalidate wipe the new entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_ENTRIES = 32;
  localparam int EA_W        = 32;
  localparam int PG_SHIFT    = 12;
  localparam int VPN_W       = EA_W - PG_SHIFT;
  localparam int ASID_W      = 4;
  localparam int GRP_W       = 3;
  localparam int SIZE_W      = 3;

  typedef struct packed {
    logic              shared;
    logic [SIZE_W-1:0] size;
    logic [ASID_W-1:0] asid;
    logic [GRP_W-1:0]  grp;
    logic [VPN_W-1:0]  epn;
    logic [VPN_W-1:0]  ppn;
  } tlb_entry_t;

  // Ones mark page-number bits that take part in the compare.
  function automatic logic [VPN_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
    logic [VPN_W-1:0] m;
    m = '1;
    case (code)
      3'd1:    m = m << 2;
      3'd2:    m = m << 6;
      3'd3:    m = m << 7;
      3'd4:    m = m << 11;
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inv_all,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  tlb_entry_t                  wr_data,
  output logic [ENTRIES-1:0]          valid_q,
  output tlb_entry_t [ENTRIES-1:0]    ent_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (inv_all) valid_q <= '0;
      if (wr_en)   valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES
) (
  input  logic [ENTRIES-1:0]                   valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]        epn,
  input  logic [ENTRIES-1:0][SIZE_W-1:0]       size,
  input  logic [ENTRIES-1:0][ASID_W-1:0]       asid,
  input  logic [ENTRIES-1:0]                   shared,
  input  logic [VPN_W-1:0]                     lk_vpn,
  input  logic [ASID_W-1:0]                    lk_asid,
  output logic [ENTRIES-1:0]                   match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] cmp_mask;
    logic             tag_eq;
    logic             space_eq;
    assign cmp_mask  = page_mask(size[g]);
    assign tag_eq    = ((epn[g] ^ lk_vpn) & cmp_mask) == '0;
    assign space_eq  = shared[g] | (asid[g] == lk_asid);
    assign match[g]  = valid[g] & tag_eq & space_eq;
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  output logic               any,
  output logic               multi,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |match;
  assign multi = (match & (match - ENTRIES'(1))) != '0;
endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [EA_W-1:0]   lk_pa,
  output logic [GRP_W-1:0]  lk_group,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_epn,
  input  logic [VPN_W-1:0]  wr_ppn,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_shared,
  input  logic [GRP_W-1:0]  wr_group,
  input  logic              inv_all
);
  tlb_entry_t                      wr_data;
  logic [ENTRIES-1:0]              valid_q;
  tlb_entry_t [ENTRIES-1:0]        ent_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   f_epn;
  logic [ENTRIES-1:0][SIZE_W-1:0]  f_size;
  logic [ENTRIES-1:0][ASID_W-1:0]  f_asid;
  logic [ENTRIES-1:0]              f_shared;
  logic [ENTRIES-1:0]              match;
  logic                            any_match;
  logic                            multi_match;
  logic [IDX_W-1:0]                win_idx;
  logic [VPN_W-1:0]                lk_vpn;
  logic [VPN_W-1:0]                win_mask;
  logic [VPN_W-1:0]                pa_vpn;

  always_comb begin
    wr_data.shared = wr_shared;
    wr_data.size   = wr_size;
    wr_data.asid   = wr_asid;
    wr_data.grp    = wr_group;
    wr_data.epn    = wr_epn;
    wr_data.ppn    = wr_ppn;
  end

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_all (inv_all),
    .wr_en   (wr_en),
    .wr_idx  (wr_index),
    .wr_data (wr_data),
    .valid_q (valid_q),
    .ent_q   (ent_q)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_fields
    assign f_epn[g]    = ent_q[g].epn;
    assign f_size[g]   = ent_q[g].size;
    assign f_asid[g]   = ent_q[g].asid;
    assign f_shared[g] = ent_q[g].shared;
  end

  assign lk_vpn = lk_ea[EA_W-1:PG_SHIFT];

  tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .valid   (valid_q),
    .epn     (f_epn),
    .size    (f_size),
    .asid    (f_asid),
    .shared  (f_shared),
    .lk_vpn  (lk_vpn),
    .lk_asid (lk_asid),
    .match   (match)
  );

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match (match),
    .any   (any_match),
    .multi (multi_match),
    .idx   (win_idx)
  );

  assign win_mask = page_mask(ent_q[win_idx].size);
  assign pa_vpn   = (ent_q[win_idx].ppn & win_mask) | (lk_vpn & ~win_mask);

  assign lk_hit   = lk_valid & any_match;
  assign lk_multi = lk_valid & multi_match;
  assign lk_pa    = lk_hit ? {pa_vpn, lk_ea[PG_SHIFT-1:0]} : '0;
  assign lk_group = lk_hit ? ent_q[win_idx].grp : '0;
endmodule

// File: rtl/tlb_multisize_chk.sv
module tlb_multisize_chk
  import tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [EA_W-1:0]   lk_ea,
  input logic              lk_hit,
  input logic              lk_multi,
  input logic [EA_W-1:0]   lk_pa,
  input logic [GRP_W-1:0]  lk_group,
  input logic              wr_en,
  input logic              inv_all
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_multi));

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && lk_group == '0));

  // R6
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[PG_SHIFT-1:0] == lk_ea[PG_SHIFT-1:0]));

  // R7
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !wr_en) |=> !lk_hit);
endmodule

bind tlb_multisize tlb_multisize_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ea    (lk_ea),
  .lk_hit   (lk_hit),
  .lk_multi (lk_multi),
  .lk_pa    (lk_pa),
  .lk_group (lk_group),
  .wr_en    (wr_en),
  .inv_all  (inv_all)
);

// File: tb/tlb_multisize_tb.sv
module tlb_multisize_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ea = '0;
  logic [3:0]  lk_asid = '0;
  logic        lk_hit, lk_multi;
  logic [31:0] lk_pa;
  logic [2:0]  lk_group;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_index = '0;
  logic [19:0] wr_epn = '0, wr_ppn = '0;
  logic [2:0]  wr_size = '0;
  logic [3:0]  wr_asid = '0;
  logic        wr_shared = 1'b0;
  logic [2:0]  wr_group = '0;
  logic        inv_all = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  logic        m_valid [32];
  logic [19:0] m_epn   [32];
  logic [19:0] m_ppn   [32];
  logic [2:0]  m_size  [32];
  logic [3:0]  m_asid  [32];
  logic        m_shared[32];
  logic [2:0]  m_grp   [32];

  always #5 clk = ~clk;

  tlb_multisize u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa), .lk_group(lk_group),
    .wr_en(wr_en), .wr_index(wr_index), .wr_epn(wr_epn), .wr_ppn(wr_ppn),
    .wr_size(wr_size), .wr_asid(wr_asid), .wr_shared(wr_shared), .wr_group(wr_group),
    .inv_all(inv_all)
  );

  // Page offset width per size code (R2, R10).
  function automatic int offbits(input logic [2:0] code);
    case (code)
      3'd1: return 14;
      3'd2: return 18;
      3'd3: return 19;
      3'd4: return 23;
      default: return 12;
    endcase
  endfunction

  function automatic logic [31:0] lowmask(input logic [2:0] code);
    return (32'd1 << offbits(code)) - 32'd1;
  endfunction

  // Expected {hit, multi, group, pa}.
  function automatic logic [36:0] ref_look(input logic v, input logic [31:0] ea, input logic [3:0] as);
    logic        hit;
    logic        multi;
    logic [2:0]  g;
    logic [31:0] pa;
    logic [31:0] lm;
    hit = 1'b0; multi = 1'b0; g = '0; pa = '0;
    if (!v) return '0;
    for (int i = 0; i < 32; i++) begin
      lm = lowmask(m_size[i]);
      if (m_valid[i] && (((ea ^ {m_epn[i], 12'h000}) & ~lm) == 32'd0) &&
          (m_shared[i] || m_asid[i] == as)) begin
        if (hit) multi = 1'b1;
        else begin
          hit = 1'b1;
          g   = m_grp[i];
          pa  = ({m_ppn[i], 12'h000} & ~lm) | (ea & lm);
        end
      end
    end
    return {hit, multi, g, pa};
  endfunction

  task automatic look(input logic v, input logic [31:0] ea, input logic [3:0] as, input string tag);
    logic [36:0] exp_v;
    logic [36:0] act_v;
    lk_valid = v; lk_ea = ea; lk_asid = as;
    #1;
    exp_v = ref_look(v, ea, as);
    act_v = {lk_hit, lk_multi, lk_group, lk_pa};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s ea=%h asid=%0d actual=%h expected=%h", tag, ea, as, act_v, exp_v);
    end
  endtask

  task automatic model_put(input int idx, input logic [19:0] epn, input logic [19:0] ppn,
                           input logic [2:0] sz, input logic [3:0] as, input logic sh, input logic [2:0] g);
    m_valid[idx] = 1'b1; m_epn[idx] = epn; m_ppn[idx] = ppn;
    m_size[idx] = sz; m_asid[idx] = as; m_shared[idx] = sh; m_grp[idx] = g;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) m_valid[i] = 1'b0;
  endtask

  task automatic drive_wr(input int idx, input logic [19:0] epn, input logic [19:0] ppn,
                          input logic [2:0] sz, input logic [3:0] as, input logic sh, input logic [2:0] g,
                          input logic inv);
    @(negedge clk);
    wr_index = 5'(idx); wr_epn = epn; wr_ppn = ppn; wr_size = sz;
    wr_asid = as; wr_shared = sh; wr_group = g; wr_en = 1'b1; inv_all = inv;
  endtask

  task automatic wr(input int idx, input logic [19:0] epn, input logic [19:0] ppn,
                    input logic [2:0] sz, input logic [3:0] as, input logic sh, input logic [2:0] g,
                    input logic inv);
    drive_wr(idx, epn, ppn, sz, as, sh, g, inv);
    @(negedge clk);
    wr_en = 1'b0; inv_all = 1'b0;
    if (inv) model_clear();
    model_put(idx, epn, ppn, sz, as, sh, g);
  endtask

  task automatic inv_pulse();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_clear();
    for (int i = 0; i < 32; i++) begin
      m_epn[i] = '0; m_ppn[i] = '0; m_size[i] = '0;
      m_asid[i] = '0; m_shared[i] = 1'b0; m_grp[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    look(1'b1, 32'h0000_0000, 4'd0, "R1 reset miss");
    look(1'b1, 32'h1234_5678, 4'd5, "R1 reset miss");

    // R2, R4, R5: each size, last byte inside and first byte past
    for (int k = 0; k < 5; k++) begin
      logic [31:0] base;
      logic [31:0] span;
      base = 32'((k + 1)) << 24;
      span = 32'd1 << offbits(3'(k));
      wr(k, base[31:12], 20'hABCDE ^ 20'(k), 3'(k), 4'd2, 1'b0, 3'(k + 1), 1'b0);
      look(1'b1, base + span - 32'd1, 4'd2, "R2 R4 R5 inside top");
      look(1'b1, base + (span >> 1) + 32'h123, 4'd2, "R2 R4 mid page");
      look(1'b1, base + span, 4'd2, "R2 just past page");
    end

    // R10: reserved size codes act as 4 KB
    wr(5, 20'h07000, 20'h55555, 3'd6, 4'd2, 1'b0, 3'd6, 1'b0);
    look(1'b1, 32'h0700_0FFF, 4'd2, "R10 reserved inside");
    look(1'b1, 32'h0700_1000, 4'd2, "R10 reserved past 4K");

    // R3: space identifier and shared flag
    wr(6, 20'h08000, 20'h11111, 3'd0, 4'd3, 1'b0, 3'd2, 1'b0);
    look(1'b1, 32'h0800_0040, 4'd3, "R3 same space hit");
    look(1'b1, 32'h0800_0040, 4'd4, "R3 other space miss");
    wr(7, 20'h09000, 20'h22222, 3'd1, 4'd1, 1'b1, 3'd5, 1'b0);
    look(1'b1, 32'h0900_2ABC, 4'd9, "R3 shared any space");

    // R6: overlapping entries, lowest index wins
    wr(20, 20'h0A000, 20'h33333, 3'd2, 4'd0, 1'b0, 3'd7, 1'b0);
    wr(10, 20'h0A000, 20'h44444, 3'd0, 4'd0, 1'b0, 3'd1, 1'b0);
    look(1'b1, 32'h0A00_0010, 4'd0, "R6 lowest index multi");
    look(1'b1, 32'h0A00_3010, 4'd0, "R6 single match in big page");

    // R8: write not visible before its edge, then replaces the slot
    drive_wr(10, 20'h0B000, 20'h66666, 3'd0, 4'd0, 1'b0, 3'd3, 1'b0);
    look(1'b1, 32'h0B00_0000, 4'd0, "R8 not yet visible");
    @(negedge clk);
    wr_en = 1'b0;
    model_put(10, 20'h0B000, 20'h66666, 3'd0, 4'd0, 1'b0, 3'd3);
    look(1'b1, 32'h0B00_0000, 4'd0, "R8 visible after edge");
    look(1'b1, 32'h0A00_0010, 4'd0, "R8 old tag replaced");

    // R9: idle request gives zeros
    look(1'b0, 32'h0B00_0000, 4'd0, "R9 idle request");

    // R7: invalidate, then invalidate with write
    inv_pulse();
    look(1'b1, 32'h0100_0000, 4'd2, "R7 cleared");
    look(1'b1, 32'h0900_0000, 4'd0, "R7 cleared shared");
    wr(3, 20'h0C000, 20'h77777, 3'd0, 4'd0, 1'b0, 3'd4, 1'b0);
    wr(4, 20'h0D000, 20'h88888, 3'd0, 4'd0, 1'b0, 3'd2, 1'b1);
    look(1'b1, 32'h0C00_0000, 4'd0, "R7 other slot cleared");
    look(1'b1, 32'h0D00_0FF0, 4'd0, "R7 write survives invalidate");

    // Random mix
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = int'($urandom % 100);
      if (op == 0) begin
        inv_pulse();
      end else if (op < 30) begin
        wr(int'($urandom % 32), {4'($urandom % 4), 16'($urandom)}, 20'($urandom),
           3'($urandom % 8), 4'($urandom % 3), ($urandom % 5) == 0, 3'($urandom), 1'b0);
      end else begin
        int          idx;
        logic [31:0] ea;
        logic [3:0]  as;
        idx = int'($urandom % 32);
        as  = 4'($urandom % 3);
        if (m_valid[idx] && ($urandom % 4) != 0) begin
          ea = ({m_epn[idx], 12'h000} & ~lowmask(m_size[idx])) | ($urandom & lowmask(m_size[idx]));
          if (($urandom % 3) != 0) as = m_asid[idx];
        end else begin
          ea = {4'($urandom % 4), 28'($urandom)};
        end
        look(($urandom % 8) != 0, ea, as, "R2 R3 R4 R5 R6 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule